// File: doc/BRIEF.md
# DCC Frame Serializer

This block turns a complete model-railway DCC command frame into the single-wire track waveform. The frame is handed over in parallel on `frame_i`. A one-cycle `go_i` pulse latches it, and the block then shifts it out from the most significant bit down. Every bit is a low phase followed by a high phase. A zero bit uses long phases and a one bit uses short phases. Phase lengths are counted in microsecond ticks, which a prescaler derives from the system clock, so the whole block runs on one clock.

The expected frame layout is 51 bits: a run of 23 ones, a zero, the address byte, a zero, the command byte, a zero, the checksum byte, and a closing one. The block does not interpret the frame. It sends whatever `FRAME_W` bits it latched. Once the high phase of the last bit has ended, `fin_o` pulses for one cycle and the line rests low.

Top module: `dcc_serializer`

## Requirements
- R1: After reset, and whenever no frame is being sent, `dcc_o` is 0 and `fin_o` is 0. The only exception is the single completion cycle defined in R7.
- R2: A 0 bit drives `dcc_o` low for `ZERO_LOW_US*CLK_PER_US` clock cycles and then high for `ZERO_HIGH_US*CLK_PER_US` cycles.
- R3: A 1 bit drives `dcc_o` low for `ONE_LOW_US*CLK_PER_US` clock cycles and then high for `ONE_HIGH_US*CLK_PER_US` cycles.
- R4: Bits go out in order from `frame_i[FRAME_W-1]` down to `frame_i[0]`.
- R5: The frame is captured at the clock edge that accepts `go_i`. The first bit's low phase starts in the cycle after that edge. Later changes of `frame_i` have no effect on the waveform.
- R6: A `go_i` pulse that arrives while a frame is being sent has no effect.
- R7: `fin_o` is 1 for exactly one cycle. That cycle directly follows the last cycle of the final bit's high phase, and `dcc_o` is 0 during it.
- R8: Each frame consists of exactly `FRAME_W` bit periods.
- R9: A `go_i` sampled in the `fin_o` cycle starts a new frame with no gap cycle.
- R10: An asynchronous active-low `rst_ni` aborts a frame in progress, sets `dcc_o` to 0, and the block accepts a new frame afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Start pulse; latches `frame_i` when the block is idle |
| frame_i | input | FRAME_W | Frame to send, sent from the MSB down |
| dcc_o | output | 1 | Serial track waveform |
| fin_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with `CLK_PER_US=4`, zero phases of 5/5 ticks and one phases of 3/2 ticks, keeping the default 51-bit frame. With these values every phase is a few cycles long, so several complete frames fit in a short run and each phase length can be checked exactly. The one-bit high phase is deliberately made different from its low phase, so a swapped or misrouted phase length shows up as a wrong run length. The frames include an all-zero payload, an all-one frame, a mid-frame `go_i` carrying a different frame, back-to-back starts and a mid-frame reset.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } dcc_state_e;
endpackage

// File: rtl/dcc_us_tick.sv
module dcc_us_tick #(
  parameter int CLK_PER_US = 100,
  localparam int PRE_W = $clog2(CLK_PER_US + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_US - 1);

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             pre_q <= '0;
    else if (!run_i)         pre_q <= '0;
    else if (pre_q == PRE_LAST) pre_q <= '0;
    else                     pre_q <= pre_q + 1'b1;
  end

  assign tick_o = run_i && (pre_q == PRE_LAST);

  p_pre_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= PRE_LAST);
endmodule

// File: rtl/dcc_phase_timer.sv
module dcc_phase_timer #(
  parameter int PH_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            tick_i,
  input  logic [PH_W-1:0] len_i,
  output logic            done_o
);
  logic [PH_W-1:0] cnt_q;

  assign done_o = tick_i && (cnt_q == len_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clear_i || done_o) cnt_q <= '0;
    else if (tick_i)          cnt_q <= cnt_q + 1'b1;
  end

  p_phase_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |-> cnt_q < len_i);
endmodule

// File: rtl/dcc_frame_shift.sv
module dcc_frame_shift #(
  parameter int FRAME_W = 51,
  localparam int IDX_W = $clog2(FRAME_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               shift_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               bit_o,
  output logic               last_o
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sh_q;
  logic [IDX_W-1:0]   idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      sh_q  <= frame_i;
      idx_q <= '0;
    end else if (shift_i) begin
      sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
      idx_q <= idx_q + 1'b1;
    end
  end

  assign bit_o  = sh_q[FRAME_W-1];
  assign last_o = (idx_q == IDX_LAST);

  p_idx_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= IDX_LAST);
  p_no_shift_past_last_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> !last_o);
endmodule

// File: rtl/dcc_serializer.sv
module dcc_serializer
  import dcc_pkg::*;
#(
  parameter int FRAME_W      = 51,
  parameter int CLK_PER_US   = 100,
  parameter int ZERO_LOW_US  = 100,
  parameter int ZERO_HIGH_US = 100,
  parameter int ONE_LOW_US   = 58,
  parameter int ONE_HIGH_US  = 58
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               go_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               dcc_o,
  output logic               fin_o
);
  localparam int MAX_ZERO = (ZERO_LOW_US > ZERO_HIGH_US) ? ZERO_LOW_US : ZERO_HIGH_US;
  localparam int MAX_ONE  = (ONE_LOW_US > ONE_HIGH_US) ? ONE_LOW_US : ONE_HIGH_US;
  localparam int MAX_PH   = (MAX_ZERO > MAX_ONE) ? MAX_ZERO : MAX_ONE;
  localparam int PH_W     = $clog2(MAX_PH + 1);

  dcc_state_e      state_q;
  logic            fin_q;
  logic            tick;
  logic            ph_done;
  logic            cur_bit;
  logic            last_bit;
  logic            load;
  logic            shift;
  logic [PH_W-1:0] ph_len;

  assign load  = (state_q == ST_IDLE) && go_i;
  assign shift = (state_q == ST_HIGH) && ph_done && !last_bit;

  always_comb begin
    if (state_q == ST_HIGH) ph_len = cur_bit ? PH_W'(ONE_HIGH_US) : PH_W'(ZERO_HIGH_US);
    else                    ph_len = cur_bit ? PH_W'(ONE_LOW_US)  : PH_W'(ZERO_LOW_US);
  end

  dcc_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (state_q != ST_IDLE),
    .tick_o(tick)
  );

  dcc_phase_timer #(.PH_W(PH_W)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(state_q == ST_IDLE),
    .tick_i (tick),
    .len_i  (ph_len),
    .done_o (ph_done)
  );

  dcc_frame_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .shift_i(shift),
    .frame_i(frame_i),
    .bit_o  (cur_bit),
    .last_o (last_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fin_q   <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (go_i) state_q <= ST_LOW;
        ST_LOW:  if (ph_done) state_q <= ST_HIGH;
        ST_HIGH: if (ph_done) begin
          if (last_bit) begin
            state_q <= ST_IDLE;
            fin_q   <= 1'b1;
          end else begin
            state_q <= ST_LOW;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dcc_o = (state_q == ST_HIGH);
  assign fin_o = fin_q;

  p_fin_line_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |-> !dcc_o);
  p_fin_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |=> !fin_o);
  p_fin_after_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fin_o) |-> $past(dcc_o));
  p_rise_on_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dcc_o) |-> $past(tick));
  p_fall_on_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dcc_o) |-> $past(tick));
  p_busy_ignores_go_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && state_q == ST_HIGH && !ph_done) |=> state_q == ST_HIGH);
endmodule

// File: tb/dcc_serializer_tb_top.sv
module dcc_serializer_tb_top;
  localparam int FRAME_W = 51;
  localparam int CPU = 4;
  localparam int ZL = 5, ZH = 5, OL = 3, OH = 2;

  typedef struct {
    logic  lvl;
    int    len;
    string req;
    bit    is_fin;
  } seg_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic go_i = 1'b0;
  logic [FRAME_W-1:0] frame_i = '0;
  logic dcc_o, fin_o;

  seg_t exp_q[$];
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit mon_en = 1'b1;
  bit done = 1'b0;

  dcc_serializer #(
    .FRAME_W(FRAME_W), .CLK_PER_US(CPU),
    .ZERO_LOW_US(ZL), .ZERO_HIGH_US(ZH), .ONE_LOW_US(OL), .ONE_HIGH_US(OH)
  ) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(go_i), .frame_i(frame_i),
    .dcc_o(dcc_o), .fin_o(fin_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic logic [FRAME_W-1:0] mk_frame(input logic [7:0] adr, input logic [7:0] cmd);
    logic [7:0] chk = adr ^ cmd;
    return {23'h7FFFFF, 1'b0, adr, 1'b0, cmd, 1'b0, chk, 1'b1};
  endfunction

  // driver: push expected waveform (MSB first, R4/R8), then pulse go
  task automatic start_frame(input logic [FRAME_W-1:0] f);
    for (int i = FRAME_W - 1; i >= 0; i--) begin
      if (f[i]) begin
        exp_q.push_back('{1'b0, OL * CPU, "R3/R4/R8", 1'b0});
        exp_q.push_back('{1'b1, OH * CPU, "R3/R4/R8", 1'b0});
      end else begin
        exp_q.push_back('{1'b0, ZL * CPU, "R2/R4/R8", 1'b0});
        exp_q.push_back('{1'b1, ZH * CPU, "R2/R4/R8", 1'b0});
      end
    end
    exp_q.push_back('{1'b0, 1, "R7", 1'b1});
    frame_i = f;
    go_i = 1'b1;
    @(negedge clk_i);
    go_i = 1'b0;
  endtask

  task automatic wait_fin();
    do @(negedge clk_i); while (!fin_o);
  endtask

  // monitor / scoreboard
  initial begin
    seg_t s;
    int bad, act;
    forever begin
      wait (exp_q.size() != 0);
      s = exp_q.pop_front();
      bad = 0;
      act = 0;
      repeat (s.len) begin
        @(negedge clk_i);
        if (s.is_fin) begin
          if (!(fin_o === 1'b1 && dcc_o === 1'b0)) begin bad++; act = {fin_o, dcc_o}; end
        end else if (dcc_o !== s.lvl || fin_o !== 1'b0) begin
          bad++;
          act = {fin_o, dcc_o};
        end
      end
      if (mon_en)
        check(bad == 0, s.req, s.is_fin ? act : bad, s.is_fin ? 2 : 0);
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    check(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  always @(posedge clk_i) cyc++;

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check(dcc_o === 1'b0 && fin_o === 1'b0, "R1", {fin_o, dcc_o}, 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    check(dcc_o === 1'b0 && fin_o === 1'b0, "R1", {fin_o, dcc_o}, 0);

    // typical command frame, frame_i changed after start (R5)
    start_frame(mk_frame(8'h03, 8'h74));
    frame_i = '0;
    // R6: go with another frame mid-transfer
    repeat (200) @(negedge clk_i);
    frame_i = '1;
    go_i = 1'b1;
    @(negedge clk_i);
    go_i = 1'b0;
    wait_fin();
    @(negedge clk_i);
    check(dcc_o === 1'b0 && fin_o === 1'b0, "R1/R5/R6", {fin_o, dcc_o}, 0);

    // all-zero payload
    repeat (3) @(negedge clk_i);
    start_frame(mk_frame(8'h00, 8'h00));
    wait_fin();
    repeat (2) @(negedge clk_i);

    // all ones, then back-to-back start in fin cycle (R9)
    start_frame('1);
    wait_fin();
    start_frame(mk_frame(8'hA5, 8'h3C));
    wait_fin();
    @(negedge clk_i);
    check(fin_o === 1'b0, "R7", fin_o, 0);

    // R10: reset mid-frame
    repeat (3) @(negedge clk_i);
    start_frame(mk_frame(8'h7F, 8'h81));
    repeat (300) @(negedge clk_i);
    mon_en = 1'b0;
    exp_q.delete();
    while (dcc_o !== 1'b1) @(negedge clk_i);
    #3 rst_ni = 1'b0;
    #2 check(dcc_o === 1'b0 && fin_o === 1'b0, "R10", {fin_o, dcc_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (60) @(negedge clk_i);
    check(dcc_o === 1'b0 && fin_o === 1'b0, "R10", {fin_o, dcc_o}, 0);
    mon_en = 1'b1;
    start_frame(mk_frame(8'h10, 8'h01));
    wait_fin();
    repeat (3) @(negedge clk_i);
    finish_run();
  end
endmodule